// File: doc/BRIEF.md
# Task-Switched Bank MMU

This block maps the 64K logical address space of an 8-bit CPU onto a 2 MB physical space. It works in 8K windows. The top three logical address bits pick one of eight windows. Each window takes an 8-bit physical bank number from a bank register. The 13-bit offset inside the window passes through unchanged.

There are two sets of eight bank registers. A task bit picks which set is live, so an operating system can switch between two address maps by flipping one bit. A global enable turns translation on. While it is off, the eight windows fall onto a fixed block of banks. A constant-page bit pins the vector page, FE00 to FEFF, to one fixed physical page, whatever the top window holds. The register page, FF00 to FFFF, is never translated and is flagged on its own output.

Software programs the block through a small register port. Offsets 0 to 15 hold the bank registers, offset 16 holds the control bits, and all other offsets are unused. The translated address and the register read data are both registered, so each appears one clock after its inputs.

Top module: `task_bank_mmu`

## Requirements
- R1: When mapping is enabled and neither override applies, phys_addr equals {bank register [task*8 + cpu_addr[15:13]], cpu_addr[12:0]}. It appears one clock after cpu_addr is sampled, and the low 13 bits always equal the sampled cpu_addr[12:0].
- R2: Control bit 0 (task) selects the bank registers at offsets 8..15 when 1 and those at offsets 0..7 when 0.
- R3: When control bit 1 (enable) is 0, window n maps to bank 0x38+n, whatever the bank registers hold.
- R4: When control bit 2 (constant page) is 1, cpu_addr FE00..FEFF maps to bank 0x3F with the offset kept. Addresses E000..FDFF still use the top window's register. With the bit at 0, FExx uses that register.
- R5: For cpu_addr FF00..FFFF, io_page is 1 and the bank is 0x3F in every mode. For any other address io_page is 0.
- R6: While rst is high, phys_addr, io_page and reg_rdata are 0. After reset, all bank registers and control bits read 0 and translation follows R3.
- R7: A read (reg_cs=1, reg_we=0) returns data on reg_rdata one clock later. For offsets 0..15 only bits 5..0 are guaranteed to equal the stored bank. Offset 16 returns the control bits in bits 2..0 and zeros above.
- R8: Offsets 17..31 read as 0, and writes to them change no register. reg_rdata holds its value in any cycle without a read.
- R9: A register write takes effect for a translation sampled on the clock after the write edge. A translation sampled on the write edge itself uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_cs | input | 1 | Register port select |
| reg_we | input | 1 | Register write (1) or read (0) when selected |
| reg_addr | input | 5 | Register offset: 0..15 bank registers, 16 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| cpu_addr | input | 16 | Logical CPU address |
| phys_addr | output | 21 | Registered physical address |
| io_page | output | 1 | Registered flag: address lies in the untranslated FFxx page |

## Verification
The assertions assume that cpu_addr, reg_cs, reg_we and reg_addr carry known values from the first clock edge after reset. They also assume that each input holds steady for a whole cycle, so the value captured at an edge is the one applied during the cycle before it. The bench therefore drives every input from time zero and changes inputs only on the falling edge. It issues a register access as a one-cycle strobe and then drops it. The assertions also exclude the first cycle after reset, when the registered outputs still hold their reset zeros rather than a translated value.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

  localparam int CTRL_W = 3;

  // Control register: bit 2 constant page, bit 1 enable, bit 0 task.
  typedef struct packed {
    logic const_pg;
    logic map_en;
    logic task_sel;
  } mmu_ctrl_t;

  typedef enum logic [1:0] {
    ROUTE_MAP = 2'd0,
    ROUTE_OFF = 2'd1,
    ROUTE_FIX = 2'd2
  } route_e;

endpackage

// File: rtl/mmu_ctrl_reg.sv
module mmu_ctrl_reg
  import mmu_pkg::*;
#(
  parameter int REG_AW   = 5,
  parameter int DATA_W   = 8,
  parameter int CTRL_OFF = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output mmu_ctrl_t         ctrl
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_en && wr_addr == REG_AW'(CTRL_OFF)) begin
      ctrl <= mmu_ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

endmodule

// File: rtl/mmu_bank_file.sv
module mmu_bank_file #(
  parameter int BANK_W = 8,
  parameter int NREG   = 16,
  parameter int IDX_W  = 4,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [BANK_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BANK_W-1:0] rd_bank,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [BANK_W-1:0] lk_bank
);

  logic [BANK_W-1:0] bank_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_q[i] <= '0;
      end else if (wr_en && wr_addr == REG_AW'(i)) begin
        bank_q[i] <= wr_data;
      end
    end
  end

  assign rd_bank = bank_q[rd_idx];
  assign lk_bank = bank_q[lk_idx];

endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 3,
  parameter int BANK_W   = 8,
  parameter int PAGE_W   = 8,
  parameter int DIS_BASE = 56,
  parameter int FIX_BANK = 63,
  parameter int VEC_PAGE = 254,
  parameter int IO_PAGE  = 255,
  localparam int OFF_W   = ADDR_W - WIN_BITS,
  localparam int PHYS_W  = BANK_W + OFF_W,
  localparam int IDX_W   = WIN_BITS + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  mmu_ctrl_t         ctrl,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic [BANK_W-1:0] lk_bank,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              io_page
);

  logic [PAGE_W-1:0]   page;
  logic [WIN_BITS-1:0] win;
  logic                io_d;
  route_e              route;
  logic [BANK_W-1:0]   bank_n;

  assign page   = cpu_addr[ADDR_W-1 -: PAGE_W];
  assign win    = cpu_addr[ADDR_W-1 -: WIN_BITS];
  assign lk_idx = {ctrl.task_sel, win};
  assign io_d   = (page == PAGE_W'(IO_PAGE));

  // Priority: register page, then constant vector page, then disabled map.
  always_comb begin
    if (io_d || (ctrl.const_pg && page == PAGE_W'(VEC_PAGE))) begin
      route = ROUTE_FIX;
    end else if (!ctrl.map_en) begin
      route = ROUTE_OFF;
    end else begin
      route = ROUTE_MAP;
    end
    case (route)
      ROUTE_FIX: bank_n = BANK_W'(FIX_BANK);
      ROUTE_OFF: bank_n = BANK_W'(DIS_BASE) + BANK_W'(win);
      default:   bank_n = lk_bank;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr <= '0;
      io_page   <= 1'b0;
    end else begin
      phys_addr <= {bank_n, cpu_addr[OFF_W-1:0]};
      io_page   <= io_d;
    end
  end

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> phys_addr[OFF_W-1:0] == $past(cpu_addr[OFF_W-1:0]));

  assert_io_flag_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> io_page == ($past(page) == PAGE_W'(IO_PAGE)));

  assert_io_bank_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && io_page) |-> phys_addr[PHYS_W-1 -: BANK_W] == BANK_W'(FIX_BANK));

  assert_vec_fix_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl.const_pg) && $past(page) == PAGE_W'(VEC_PAGE))
    |-> phys_addr[PHYS_W-1 -: BANK_W] == BANK_W'(FIX_BANK));

  assert_off_base_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ctrl.map_en) && !io_page &&
     !($past(ctrl.const_pg) && $past(page) == PAGE_W'(VEC_PAGE)))
    |-> phys_addr[PHYS_W-1 -: BANK_W] == BANK_W'(DIS_BASE) + BANK_W'($past(win)));

endmodule

// File: rtl/task_bank_mmu.sv
module task_bank_mmu
  import mmu_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 3,
  parameter int BANK_W   = 8,
  parameter int PAGE_W   = 8,
  parameter int DIS_BASE = 56,
  parameter int FIX_BANK = 63,
  parameter int VEC_PAGE = 254,
  parameter int IO_PAGE  = 255,
  localparam int NWIN    = 1 << WIN_BITS,
  localparam int NREG    = 2 * NWIN,
  localparam int IDX_W   = WIN_BITS + 1,
  localparam int REG_AW  = IDX_W + 1,
  localparam int OFF_W   = ADDR_W - WIN_BITS,
  localparam int PHYS_W  = BANK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_cs,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [BANK_W-1:0] reg_wdata,
  output logic [BANK_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              io_page
);

  mmu_ctrl_t         ctrl;
  logic              wr_en;
  logic              rd_en;
  logic              bank_hit;
  logic              ctrl_hit;
  logic [IDX_W-1:0]  lk_idx;
  logic [BANK_W-1:0] lk_bank;
  logic [BANK_W-1:0] rd_bank;

  assign wr_en    = reg_cs && reg_we;
  assign rd_en    = reg_cs && !reg_we;
  assign bank_hit = !reg_addr[REG_AW-1];
  assign ctrl_hit = (reg_addr == REG_AW'(NREG));

  mmu_ctrl_reg #(
    .REG_AW  (REG_AW),
    .DATA_W  (BANK_W),
    .CTRL_OFF(NREG)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(reg_addr),
    .wr_data(reg_wdata),
    .ctrl   (ctrl)
  );

  mmu_bank_file #(
    .BANK_W(BANK_W),
    .NREG  (NREG),
    .IDX_W (IDX_W),
    .REG_AW(REG_AW)
  ) u_banks (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(reg_addr),
    .wr_data(reg_wdata),
    .rd_idx (reg_addr[IDX_W-1:0]),
    .rd_bank(rd_bank),
    .lk_idx (lk_idx),
    .lk_bank(lk_bank)
  );

  mmu_xlate #(
    .ADDR_W  (ADDR_W),
    .WIN_BITS(WIN_BITS),
    .BANK_W  (BANK_W),
    .PAGE_W  (PAGE_W),
    .DIS_BASE(DIS_BASE),
    .FIX_BANK(FIX_BANK),
    .VEC_PAGE(VEC_PAGE),
    .IO_PAGE (IO_PAGE)
  ) u_xlate (
    .clk      (clk),
    .rst      (rst),
    .cpu_addr (cpu_addr),
    .ctrl     (ctrl),
    .lk_idx   (lk_idx),
    .lk_bank  (lk_bank),
    .phys_addr(phys_addr),
    .io_page  (io_page)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (rd_en) begin
      if (bank_hit)      reg_rdata <= rd_bank;
      else if (ctrl_hit) reg_rdata <= {{(BANK_W-CTRL_W){1'b0}}, ctrl};
      else               reg_rdata <= '0;
    end
  end

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_en)) |-> $stable(reg_rdata));

endmodule

// File: tb/task_bank_mmu_tb.sv
module task_bank_mmu_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_cs = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] cpu_addr = '0;
  logic [20:0] phys_addr;
  logic        io_page;

  always #5 clk = ~clk;

  task_bank_mmu u_dut (
    .clk      (clk),
    .rst      (rst),
    .reg_cs   (reg_cs),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .cpu_addr (cpu_addr),
    .phys_addr(phys_addr),
    .io_page  (io_page)
  );

  typedef struct {
    int          kind;   // 0 translation, 1 register read
    logic [20:0] phys;
    logic        io;
    logic [7:0]  rd;
    logic [7:0]  mask;
    int          req;
    longint      due;
  } item_t;

  item_t  sb_q[$];
  longint cyc = 0;
  int     n_run = 0;
  int     n_fail = 0;
  bit     done = 1'b0;

  // Reference model of the programmed state.
  logic [7:0] m_bank [16];
  logic       m_task = 1'b0;
  logic       m_en = 1'b0;
  logic       m_const = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [20:0] model_phys(input logic [15:0] a);
    logic [7:0] b;
    if (a[15:8] == 8'hFF || (m_const && a[15:8] == 8'hFE)) b = 8'h3F;
    else if (!m_en) b = 8'h38 + {5'd0, a[15:13]};
    else b = m_bank[{m_task, a[15:13]}];
    return {b, a[12:0]};
  endfunction

  function automatic logic [7:0] model_rd(input logic [4:0] off);
    if (off < 5'd16) return m_bank[off[3:0]];
    if (off == 5'd16) return {5'd0, m_const, m_en, m_task};
    return 8'h00;
  endfunction

  function automatic void model_write(input logic [4:0] off, input logic [7:0] d);
    if (off < 5'd16) m_bank[off[3:0]] = d;
    else if (off == 5'd16) {m_const, m_en, m_task} = d[2:0];
  endfunction

  task automatic push_xlate(input logic [15:0] a, input int req);
    item_t it;
    it.kind = 0; it.phys = model_phys(a); it.io = (a[15:8] == 8'hFF);
    it.rd = '0; it.mask = '0; it.req = req; it.due = cyc + 1;
    sb_q.push_back(it);
  endtask

  task automatic do_xlate(input logic [15:0] a, input int req);
    @(negedge clk);
    cpu_addr = a;
    push_xlate(a, req);
  endtask

  task automatic do_write(input logic [4:0] off, input logic [7:0] d);
    @(negedge clk);
    reg_cs = 1'b1; reg_we = 1'b1; reg_addr = off; reg_wdata = d;
    model_write(off, d);
    @(negedge clk);
    reg_cs = 1'b0; reg_we = 1'b0;
  endtask

  task automatic do_read(input logic [4:0] off, input logic [7:0] mask, input int req);
    item_t it;
    @(negedge clk);
    reg_cs = 1'b1; reg_we = 1'b0; reg_addr = off;
    it.kind = 1; it.phys = '0; it.io = 1'b0; it.rd = model_rd(off);
    it.mask = mask; it.req = req; it.due = cyc + 1;
    sb_q.push_back(it);
    @(negedge clk);
    reg_cs = 1'b0;
  endtask

  // R9: write and translation in the same cycle, then again one cycle later.
  task automatic write_and_xlate(input logic [4:0] off, input logic [7:0] d,
                                 input logic [15:0] a);
    @(negedge clk);
    reg_cs = 1'b1; reg_we = 1'b1; reg_addr = off; reg_wdata = d;
    cpu_addr = a;
    push_xlate(a, 9);
    model_write(off, d);
    @(negedge clk);
    reg_cs = 1'b0; reg_we = 1'b0;
    push_xlate(a, 9);
  endtask

  task automatic check_direct(input logic [20:0] act, input logic [20:0] exp, input int req,
                              input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: compares results as they emerge, in issue order.
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      item_t it;
      it = sb_q.pop_front();
      n_run++;
      if (it.kind == 0) begin
        if (phys_addr !== it.phys || io_page !== it.io) begin
          n_fail++;
          $display("FAIL R%0d translate: actual phys %h io %b expected phys %h io %b",
                   it.req, phys_addr, io_page, it.phys, it.io);
        end
      end else begin
        if ((reg_rdata & it.mask) !== (it.rd & it.mask)) begin
          n_fail++;
          $display("FAIL R%0d read: actual %h expected %h (mask %h)",
                   it.req, reg_rdata & it.mask, it.rd & it.mask, it.mask);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_bank[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R6: outputs held at zero during reset
    check_direct(phys_addr, 21'd0, 6, "phys_addr in reset");
    check_direct({20'd0, io_page}, 21'd0, 6, "io_page in reset");
    check_direct({13'd0, reg_rdata}, 21'd0, 6, "reg_rdata in reset");
    rst = 1'b0;

    // R6: after reset mapping is off and registers read zero
    do_xlate(16'h1234, 6);
    do_read(5'd3, 8'h3F, 6);
    do_read(5'd16, 8'hFF, 6);

    // R3: disabled map, every window
    for (int w = 0; w < 8; w++) do_xlate({w[2:0], 13'h0ABC}, 3);

    // R7: program both sets with full 8-bit values, read back low 6 bits
    for (int i = 0; i < 8; i++) begin
      do_write(5'(i), 8'h10 + 8'(i));
      do_write(5'(i + 8), 8'hC0 + 8'(i));
    end
    for (int i = 0; i < 16; i++) do_read(5'(i), 8'h3F, 7);

    // R3: programmed registers still ignored while disabled
    do_xlate(16'h4000, 3);

    // R1: enable, task 0
    do_write(5'd16, 8'h02);
    for (int w = 0; w < 8; w++) do_xlate({w[2:0], 13'h1555}, 1);
    do_xlate(16'h1FFF, 1);
    do_xlate(16'h2000, 1);
    do_xlate(16'hFE40, 4);   // R4: constant page off, FExx uses top window

    // R2: task 1 selects offsets 8..15
    do_write(5'd16, 8'h03);
    for (int w = 0; w < 8; w++) do_xlate({w[2:0], 13'h0F0F}, 2);

    // R4: constant page on
    do_write(5'd16, 8'h07);
    do_xlate(16'hFE40, 4);
    do_xlate(16'hFEFF, 4);
    do_xlate(16'hFE00, 4);
    do_xlate(16'hFDFF, 4);
    do_xlate(16'hE000, 4);

    // R5: register page in enabled and disabled modes
    do_xlate(16'hFF00, 5);
    do_xlate(16'hFFFF, 5);
    do_write(5'd16, 8'h04);
    do_xlate(16'hFF80, 5);
    do_xlate(16'hFE10, 4);
    do_xlate(16'hC123, 3);

    // R7: control readback
    do_read(5'd16, 8'hFF, 7);

    // R8: unused offsets read zero and write nothing
    do_write(5'd17, 8'hFF);
    do_write(5'd31, 8'hFF);
    do_read(5'd17, 8'hFF, 8);
    do_read(5'd16, 8'hFF, 8);
    do_read(5'd5, 8'h3F, 8);
    repeat (3) @(negedge clk);
    check_direct({13'd0, reg_rdata & 8'h3F}, 21'h15, 8, "reg_rdata hold");

    // R9: same-edge write sees old value, next cycle sees new
    write_and_xlate(5'd16, 8'h02, 16'h6000);
    write_and_xlate(5'd3, 8'h2A, 16'h6001);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule